// File: doc/BRIEF.md
# Swallow-Counter Programmable Frequency Divider

This block divides an RF signal for a tuning synthesizer. In the FM/SW band it runs as the digital half of a swallow divider. Its clock is the output of an external four-modulus prescaler (32/33/64/65). Over each output period it tells the prescaler, through a two-bit modulus code, whether to divide by its base modulus or by base plus one. With a program count P and a swallow count S (S below P), the overall division from RF to output is P·N + S, where N is 32 or 64. In the LW/MW band the swallow stage is idle and a single 14-bit direct counter divides the AM input. The clock then comes straight from the AM amplifier.

Each output period ends with a pulse one clock wide that goes to the phase detector. The count words, the band select and the range bit are sampled only at that reload point. A word written in the middle of a period therefore never shortens or stretches the period already running. Standby freezes both counters and keeps the output pulse low. Counting continues from the frozen state once standby is released.

Top module: `swallow_divider`

## Requirements
- R1: While rst_n is low, div_pulse is 0 and mod_ctl is 2'b00; every count register is cleared.
- R2: With am_band = 0 and prog_word = P (P >= 2), consecutive div_pulse assertions are exactly P clock cycles apart.
- R3: With am_band = 1 and am_word = A (A >= 2), consecutive div_pulse assertions are exactly A clock cycles apart, for any A up to 16383.
- R4: A selected count word of 0 or 1 gives a period of 2 cycles in both bands.
- R5: mod_ctl[0] (plus-one) is 1 during the first min(S, period) cycles of each FM/SW period, starting with the cycle in which div_pulse is high, and 0 for the rest; it only rises together with div_pulse, and it is 0 for the whole period in the AM band.
- R6: mod_ctl[1] (range: 0 selects 32/33, 1 selects 64/65) equals range_hi as sampled at the period's reload and changes only at a reload; in the AM band it is 0 whatever range_hi is.
- R7: div_pulse is high for exactly one clock cycle per period.
- R8: Changes to am_band, range_hi or the count words during a period take effect only at the next reload; the running period keeps its length.
- R9: A clock edge that samples standby = 1 leaves the counters and mod_ctl unchanged and drives div_pulse to 0, so a period is lengthened by the number of such cycles.
- R10: After rst_n rises, the first div_pulse appears in the cycle after the third rising clock edge (two edges of reset synchronization, then an immediate reload).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Divider clock: prescaler output in FM/SW, AM input in LW/MW |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| standby | input | 1 | High freezes the divider and silences the output |
| am_band | input | 1 | 0 = FM/SW swallow mode, 1 = LW/MW direct mode |
| range_hi | input | 1 | Prescaler range request: 0 = 32/33, 1 = 64/65 |
| prog_word | input | 8 | Program count P for FM/SW |
| swal_word | input | 6 | Swallow count S for FM/SW |
| am_word | input | 14 | Direct count A for LW/MW |
| mod_ctl | output | 2 | Prescaler modulus code {range, plus_one} |
| div_pulse | output | 1 | One-cycle pulse at the end of each output period |

## Verification
The hardest case to reach from the ports is a word change or a standby stretch that falls inside a running period. It only means something relative to the reload edge, which is not directly visible. The stimulus aligns itself to div_pulse: each driver step begins in the pulse cycle. It then writes a throw-away word, overwrites it one cycle later, and, in a chosen period, raises standby a fixed number of cycles after the pulse. The expected period lengths and plus-one counts are known in advance for these cases. Steps that drop the period to two cycles check that back-to-back reloads still take the words that were present at each reload.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;

  typedef enum logic {
    BAND_SWALLOW = 1'b0,
    BAND_DIRECT  = 1'b1
  } band_e;

  localparam int unsigned MIN_PERIOD = 2;

endpackage

// File: rtl/swdiv_reset_sync.sv
module swdiv_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/swdiv_reload_calc.sv
module swdiv_reload_calc
  import swdiv_pkg::*;
#(
  parameter int unsigned PROG_W = 8,
  parameter int unsigned SWAL_W = 6,
  parameter int unsigned DIR_W  = 14,
  parameter int unsigned CNT_W  = (DIR_W > PROG_W) ? DIR_W : PROG_W
) (
  input  band_e             band,
  input  logic [PROG_W-1:0] prog_word,
  input  logic [SWAL_W-1:0] swal_word,
  input  logic [DIR_W-1:0]  dir_word,
  output logic [CNT_W-1:0]  cnt_init,
  output logic [SWAL_W-1:0] swal_init
);

  localparam logic [CNT_W-1:0] PERIOD_FLOOR = CNT_W'(MIN_PERIOD);

  logic [CNT_W-1:0] raw_period;
  logic [CNT_W-1:0] period;

  always_comb begin
    if (band == BAND_DIRECT) raw_period = CNT_W'(dir_word);
    else                     raw_period = CNT_W'(prog_word);
  end

  always_comb begin
    if (raw_period < PERIOD_FLOOR) period = PERIOD_FLOOR;
    else                           period = raw_period;
  end

  // The terminal-count cycle is part of the period, so load period - 1.
  assign cnt_init  = period - CNT_W'(1);
  assign swal_init = (band == BAND_SWALLOW) ? swal_word : '0;

endmodule

// File: rtl/swdiv_main_counter.sv
module swdiv_main_counter #(
  parameter int unsigned CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] load_val,
  output logic             reload,
  output logic             pulse
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pulse_q, pulse_d;
  logic             at_terminal;

  assign at_terminal = (cnt_q == '0);
  assign reload      = cnt_en && at_terminal;

  always_comb begin
    cnt_d   = cnt_q;
    pulse_d = 1'b0;
    if (cnt_en) begin
      if (at_terminal) begin
        cnt_d   = load_val;
        pulse_d = 1'b1;
      end else begin
        cnt_d   = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse = pulse_q;

endmodule

// File: rtl/swdiv_swallow_stage.sv
module swdiv_swallow_stage #(
  parameter int unsigned SWAL_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic              reload,
  input  logic [SWAL_W-1:0] load_val,
  output logic              plus_one
);

  logic [SWAL_W-1:0] swal_q, swal_d;
  logic              swal_busy;

  assign swal_busy = (swal_q != '0);

  always_comb begin
    swal_d = swal_q;
    if (cnt_en) begin
      if (reload)         swal_d = load_val;
      else if (swal_busy) swal_d = swal_q - SWAL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) swal_q <= '0;
    else        swal_q <= swal_d;
  end

  assign plus_one = swal_busy;

endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
  import swdiv_pkg::*;
#(
  parameter int unsigned PROG_W      = 8,
  parameter int unsigned SWAL_W      = 6,
  parameter int unsigned DIR_W       = 14,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby,
  input  logic              am_band,
  input  logic              range_hi,
  input  logic [PROG_W-1:0] prog_word,
  input  logic [SWAL_W-1:0] swal_word,
  input  logic [DIR_W-1:0]  am_word,
  output logic [1:0]        mod_ctl,
  output logic              div_pulse
);

  localparam int unsigned CNT_W = (DIR_W > PROG_W) ? DIR_W : PROG_W;

  logic              rst_sync_n;
  logic              cnt_en;
  logic              reload;
  logic              plus_one;
  logic [CNT_W-1:0]  cnt_init;
  logic [SWAL_W-1:0] swal_init;
  band_e             band_sel;
  logic              act_am_q, act_am_d;
  logic              act_range_q, act_range_d;

  assign band_sel = band_e'(am_band);
  assign cnt_en   = ~standby;

  swdiv_reset_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  swdiv_reload_calc #(
    .PROG_W (PROG_W),
    .SWAL_W (SWAL_W),
    .DIR_W  (DIR_W),
    .CNT_W  (CNT_W)
  ) u_reload_calc (
    .band      (band_sel),
    .prog_word (prog_word),
    .swal_word (swal_word),
    .dir_word  (am_word),
    .cnt_init  (cnt_init),
    .swal_init (swal_init)
  );

  swdiv_main_counter #(
    .CNT_W (CNT_W)
  ) u_main_counter (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cnt_en   (cnt_en),
    .load_val (cnt_init),
    .reload   (reload),
    .pulse    (div_pulse)
  );

  swdiv_swallow_stage #(
    .SWAL_W (SWAL_W)
  ) u_swallow (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cnt_en   (cnt_en),
    .reload   (reload),
    .load_val (swal_init),
    .plus_one (plus_one)
  );

  // Band and range for the running period are captured only at reload.
  always_comb begin
    act_am_d    = act_am_q;
    act_range_d = act_range_q;
    if (reload) begin
      act_am_d    = (band_sel == BAND_DIRECT);
      act_range_d = range_hi;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      act_am_q    <= 1'b0;
      act_range_q <= 1'b0;
    end else begin
      act_am_q    <= act_am_d;
      act_range_q <= act_range_d;
    end
  end

  assign mod_ctl = act_am_q ? 2'b00 : {act_range_q, plus_one};

endmodule

// File: rtl/swdiv_checker.sv
module swdiv_checker (
  input logic       clk,
  input logic       rst_ni,
  input logic       standby,
  input logic       div_pulse,
  input logic [1:0] mod_ctl,
  input logic       act_am
);

  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    div_pulse |=> !div_pulse);

  assert_standby_quiet_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    standby |=> !div_pulse);

  assert_standby_hold_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    standby |=> $stable(mod_ctl));

  assert_am_code_idle_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    act_am |-> (mod_ctl == 2'b00));

  assert_plus_rise_at_reload_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(mod_ctl[0]) |-> div_pulse);

  assert_range_static_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    !div_pulse |-> $stable(mod_ctl[1]));

endmodule

bind swallow_divider swdiv_checker u_swdiv_checker (
  .clk       (clk),
  .rst_ni    (rst_sync_n),
  .standby   (standby),
  .div_pulse (div_pulse),
  .mod_ctl   (mod_ctl),
  .act_am    (act_am_q)
);

// File: tb/test_swallow_divider.sv
`timescale 1ns/1ps
module test_swallow_divider;

  typedef struct {
    int   gap;
    int   plus;
    logic rng;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        standby;
  logic        am_band;
  logic        range_hi;
  logic [7:0]  prog_word;
  logic [5:0]  swal_word;
  logic [13:0] am_word;
  logic [1:0]  mod_ctl;
  logic        div_pulse;

  int   n_checks = 0;
  int   n_fails  = 0;
  exp_t exp_q[$];
  int   pending_sb = 0;
  logic sb_edge = 1'b0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  swallow_divider i_swallow_divider (
    .clk       (clk),
    .rst_n     (rst_n),
    .standby   (standby),
    .am_band   (am_band),
    .range_hi  (range_hi),
    .prog_word (prog_word),
    .swal_word (swal_word),
    .am_word   (am_word),
    .mod_ctl   (mod_ctl),
    .div_pulse (div_pulse)
  );

  task automatic check(input logic ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic exp_t model(input logic am, input int p, input int s,
                                 input logic r, input int a, input int extra);
    exp_t e;
    int   per;
    per = am ? a : p;
    if (per < 2) per = 2;
    e.gap  = per + extra;
    e.plus = am ? 0 : ((s < per) ? s : per);
    e.rng  = am ? 1'b0 : r;
    return e;
  endfunction

  task automatic set_words(input logic am, input int p, input int s, input logic r, input int a);
    am_band   = am;
    prog_word = 8'(p);
    swal_word = 6'(s);
    range_hi  = r;
    am_word   = 14'(a);
  endtask

  task automatic wait_pulse();
    do @(negedge clk); while (div_pulse !== 1'b1);
  endtask

  // Called in a pulse cycle: the words set here define the next period.
  task automatic step(input logic am, input int p, input int s, input logic r,
                      input int a, input int sb_next, input logic mid);
    if (mid) begin
      set_words(1'b0, 3, 2, 1'b1, 7);
      @(negedge clk);
    end
    set_words(am, p, s, r, a);
    exp_q.push_back(model(am, p, s, r, a, sb_next));
    if (pending_sb > 0) begin
      repeat (2) @(negedge clk);
      standby = 1'b1;
      repeat (pending_sb) @(negedge clk);
      standby = 1'b0;
    end
    pending_sb = sb_next;
    wait_pulse();
  endtask

  always @(posedge clk) sb_edge <= standby;

  // Monitor: measures each period and compares with the scoreboard.
  initial begin : monitor
    int   cyc;
    int   plus;
    logic rng;
    logic started;
    exp_t e;
    started = 1'b0;
    cyc = 0;
    plus = 0;
    rng = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1) begin
        if (sb_edge) check(div_pulse == 1'b0, "R9 pulse low in standby", int'(div_pulse), 0);
        if (div_pulse) begin
          if (started) begin
            if (exp_q.size() == 0) begin
              check(1'b0, "R2 scoreboard underflow", 0, 1);
            end else begin
              e = exp_q.pop_front();
              check(cyc == e.gap, "R2/R3/R4/R8/R9 period length", cyc, e.gap);
              check(plus == e.plus, "R5 plus-one cycles", plus, e.plus);
              check(rng == e.rng, "R6 range bit", int'(rng), int'(e.rng));
            end
          end
          started = 1'b1;
          cyc  = 1;
          plus = mod_ctl[0] ? 1 : 0;
          rng  = mod_ctl[1];
        end else if (started) begin
          cyc++;
          if (mod_ctl[0]) plus++;
          check(div_pulse == 1'b0, "R7 single-cycle pulse", int'(div_pulse), 0);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin : driver
    rst_n   = 1'b0;
    standby = 1'b0;
    set_words(1'b0, 5, 2, 1'b1, 0);
    repeat (3) @(negedge clk);
    check(div_pulse == 1'b0, "R1 reset pulse", int'(div_pulse), 0);
    check(mod_ctl == 2'b00, "R1 reset code", int'(mod_ctl), 0);
    exp_q.push_back(model(1'b0, 5, 2, 1'b1, 0, 0));
    rst_n = 1'b1;
    @(negedge clk);
    check(div_pulse == 1'b0, "R10 no pulse after edge 1", int'(div_pulse), 0);
    @(negedge clk);
    check(div_pulse == 1'b0, "R10 no pulse after edge 2", int'(div_pulse), 0);
    @(negedge clk);
    check(div_pulse == 1'b1, "R10 first pulse after edge 3", int'(div_pulse), 1);

    step(1'b0,   7,  3, 1'b0,     0, 0, 1'b0);  // R2 R5 R6
    step(1'b0,   4,  4, 1'b1,     0, 0, 1'b0);  // R5 S equal to P
    step(1'b0,   4,  9, 1'b1,     0, 0, 1'b0);  // R5 S above P
    step(1'b1,   0,  5, 1'b1,    10, 0, 1'b0);  // R3 R6 range masked in AM
    step(1'b1,   0,  0, 1'b0,     1, 0, 1'b0);  // R4 direct word 1
    step(1'b1,   0,  0, 1'b0,     0, 0, 1'b0);  // R4 direct word 0
    step(1'b0,   1,  0, 1'b1,     0, 0, 1'b0);  // R4 program word 1
    step(1'b0,   6,  1, 1'b0,     0, 0, 1'b0);
    step(1'b0,   9,  0, 1'b0,     0, 4, 1'b1);  // R8 mid-period rewrite, R9 next
    step(1'b0,   5,  2, 1'b1,     0, 0, 1'b0);  // R9 standby applied here
    step(1'b1,   0,  0, 1'b0, 16383, 0, 1'b0);  // R3 full 14-bit count
    step(1'b0, 255, 63, 1'b0,     0, 0, 1'b0);  // R2 R5 full program and swallow
    step(1'b0,   3,  1, 1'b0,     0, 0, 1'b0);
    step(1'b0,   3,  0, 1'b0,     0, 0, 1'b0);

    for (int i = 0; i < 60000 && exp_q.size() != 0; i++) @(negedge clk);
    check(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule